// File: doc/BRIEF.md
# Programmable Serial Command Shifter

This block is a generic command engine for a serial flash device. Software describes a frame through a small register file: a bit count, and up to six program-data bytes holding the opcode followed by any transmit bytes. It then writes a command code. The engine drives chip select low and shifts the frame out most-significant bit first, one bit per clock. At the same time it samples the serial input into a capture chain that software reads back afterwards.

Two fixed commands use the same datapath. One reads the device status byte into a dedicated register. The other writes the device status by sending a fixed opcode ahead of the program-data bytes. While a frame is in flight the command register reads back the active code, and every register write is refused. When the frame ends the command register reads zero, which is the completion flag that software polls.

Register word addresses: 0 command, 1 bit count, 2 status result, 3+i program-data byte i (i = 0..5), 9+k capture byte k (k = 0..9). Unmapped addresses read as zero.

Top module: `ser_cmd_shifter`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `spi_cs_n` is high.
- R2: While idle, writes to the count register and to the program-data registers (addresses 3..8) are stored and read back unchanged. While a frame is in flight, writes to any register have no effect.
- R3: Writing code 0x04 to the command register while idle starts a generic frame. `spi_cs_n` is low for exactly the programmed number of bits, one bit per clock, starting on the cycle after the write. If the count is 0, no frame starts.
- R4: In a generic frame, `spi_sdo` carries program-data byte 5, then byte 4, and so on down to byte 0, each most-significant bit first. Zeros follow after 48 bits. `spi_sdo` is 0 whenever chip select is high.
- R5: During a generic frame, each `spi_sdi` bit is sampled at the clock edge that ends its bit period. It is shifted into bit 0 of an 80-bit capture chain. Capture register k (address 9+k) reads chain bits 8k+7..8k, so the last received byte is in capture 0, and for an N-byte response the first byte is in capture N-1.
- R6: The command register reads back the active command code while a frame is in flight, and reads 0 once it ends.
- R7: Code 0x02 sends the fixed opcode 0x05 followed by 8 further clocks, 16 bits in all, regardless of the count register. The last 8 sampled bits land in the status register (address 2). The capture chain is unchanged.
- R8: Code 0x20 sends the fixed opcode 0x01, then the programmed count of bits taken from program-data byte 5 downward. The capture chain is unchanged.
- R9: Command codes other than 0x04, 0x02 and 0x20 start nothing, and neither does any command written while a frame is in flight.
- R10: A count above 56 is shifted as 56 bits. The count register still reads back the value that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sdo | output | 1 | Serial data out |
| spi_sdi | input | 1 | Serial data in |

## Verification
A wrong bit counter shows at the pins on the very cycle the frame should have ended: chip select stays low or rises early. The bench compares the pins against a model on every clock, so this is caught at once. A misordered transmit shifter puts a wrong `spi_sdo` bit on the first cycle that carries the bad bit. A faulty capture chain or status register stays hidden until software reads it, so the bench reads every capture byte after each frame. A wrong busy gate shows as a frame that started, or a register that changed, when it should not have. These are checked at the next readback or on the next clock.

// File: rtl/snc_pkg.sv
// Package: shared constants and types for the serial command shifter.
// Assumes one serial bit per system clock.
package snc_pkg;
    localparam int BYTE_W   = 8;
    localparam int PRG_N    = 6;                      // program-data bytes
    localparam int CAP_N    = 10;                     // capture window bytes
    localparam int MAX_BITS = 56;                     // longest generic frame
    localparam int TX_W     = BYTE_W * (PRG_N + 2);   // opcode + prg + pad
    localparam int CAP_W    = BYTE_W * CAP_N;
    localparam int PRG_W    = BYTE_W * PRG_N;
    localparam int LEFT_W   = $clog2(TX_W + 1);
    localparam int ADDR_W   = 5;

    localparam logic [ADDR_W-1:0] A_CMD  = 5'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 5'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 5'd2;
    localparam int                A_PRG0 = 3;
    localparam int                A_CAP0 = A_PRG0 + PRG_N;

    localparam logic [7:0] CODE_GEN  = 8'h04;
    localparam logic [7:0] CODE_RDST = 8'h02;
    localparam logic [7:0] CODE_WRST = 8'h20;
    localparam logic [7:0] OP_RDST   = 8'h05;
    localparam logic [7:0] OP_WRST   = 8'h01;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_GEN  = 2'd1,
        M_RDST = 2'd2,
        M_WRST = 2'd3
    } mode_e;
endpackage

// File: rtl/snc_regs.sv
// Register file: holds the count and program-data bytes, and decodes a
// command write into a start request. Assumes the engine refuses starts it
// does not recognise. All writes are blocked while busy_i is high.
module snc_regs
    import snc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              busy_i,
    input  logic [7:0]        active_code_i,
    input  logic [7:0]        status_i,
    input  logic [CAP_W-1:0]  cap_i,
    output logic [7:0]        count_o,
    output logic [PRG_W-1:0]  prg_o,
    output logic              start_o,
    output logic [7:0]        code_o,
    output logic [7:0]        rdata_o
);
    logic [7:0]       count_q;
    logic [PRG_W-1:0] prg_q;
    logic             wr_ok;

    assign wr_ok   = we_i && !busy_i;
    assign start_o = wr_ok && (addr_i == A_CMD);
    assign code_o  = wdata_i;
    assign count_o = count_q;
    assign prg_o   = prg_q;

    // Store count and program-data writes accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            prg_q   <= '0;
        end else if (wr_ok) begin
            if (addr_i == A_CNT) count_q <= wdata_i;
            for (int i = 0; i < PRG_N; i++) begin
                if (addr_i == ADDR_W'(A_PRG0 + i))
                    prg_q[i*BYTE_W +: BYTE_W] <= wdata_i;
            end
        end
    end

    // Read-back multiplexer over the whole register map.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CMD)  rdata_o = active_code_i;
        if (addr_i == A_CNT)  rdata_o = count_q;
        if (addr_i == A_STAT) rdata_o = status_i;
        for (int i = 0; i < PRG_N; i++)
            if (addr_i == ADDR_W'(A_PRG0 + i)) rdata_o = prg_q[i*BYTE_W +: BYTE_W];
        for (int k = 0; k < CAP_N; k++)
            if (addr_i == ADDR_W'(A_CAP0 + k)) rdata_o = cap_i[k*BYTE_W +: BYTE_W];
    end

    assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(count_q) && $stable(prg_q)));
endmodule

// File: rtl/snc_engine.sv
// Frame engine: on an accepted start, loads the transmit shifter and the bit
// counter for the decoded mode, then shifts one bit per clock MSB first.
// Assumes start_i only pulses while busy_o is low.
module snc_engine
    import snc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       code_i,
    input  logic [7:0]       count_i,
    input  logic [PRG_W-1:0] prg_i,
    output logic             busy_o,
    output logic             sdo_o,
    output mode_e            mode_o,
    output logic [7:0]       active_code_o
);
    logic [TX_W-1:0]   tx_q, ld_tx;
    logic [LEFT_W-1:0] left_q, ld_left, clamp;
    mode_e             mode_q, ld_mode;
    logic              ld_ok;
    logic [PRG_W-1:0]  prg_seq;

    // Program bytes in wire order: byte 5 first, down to byte 0.
    always_comb begin
        for (int i = 0; i < PRG_N; i++)
            prg_seq[(PRG_N-1-i)*BYTE_W +: BYTE_W] = prg_i[(PRG_N-1-i)*BYTE_W +: BYTE_W];
    end

    assign clamp = (count_i > 8'(MAX_BITS)) ? LEFT_W'(MAX_BITS) : LEFT_W'(count_i);

    // Decode the command code into a frame shape.
    always_comb begin
        ld_ok   = 1'b0;
        ld_tx   = '0;
        ld_left = '0;
        ld_mode = M_IDLE;
        case (code_i)
            CODE_GEN: begin
                ld_ok   = (clamp != '0);
                ld_tx   = {prg_seq, {(TX_W-PRG_W){1'b0}}};
                ld_left = clamp;
                ld_mode = M_GEN;
            end
            CODE_RDST: begin
                ld_ok   = 1'b1;
                ld_tx   = {OP_RDST, {(TX_W-8){1'b0}}};
                ld_left = LEFT_W'(16);
                ld_mode = M_RDST;
            end
            CODE_WRST: begin
                ld_ok   = 1'b1;
                ld_tx   = {OP_WRST, prg_seq, {(TX_W-PRG_W-8){1'b0}}};
                ld_left = LEFT_W'(8) + clamp;
                ld_mode = M_WRST;
            end
            default: ;
        endcase
    end

    // Shift and count down while busy; load a new frame when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            left_q <= '0;
            mode_q <= M_IDLE;
        end else if (busy_o) begin
            tx_q   <= tx_q << 1;
            left_q <= left_q - 1'b1;
        end else if (start_i && ld_ok) begin
            tx_q   <= ld_tx;
            left_q <= ld_left;
            mode_q <= ld_mode;
        end
    end

    assign busy_o = (left_q != '0);
    assign sdo_o  = busy_o & tx_q[TX_W-1];
    assign mode_o = busy_o ? mode_q : M_IDLE;

    // Report the running command code for read-back.
    always_comb begin
        case (mode_o)
            M_GEN:   active_code_o = CODE_GEN;
            M_RDST:  active_code_o = CODE_RDST;
            M_WRST:  active_code_o = CODE_WRST;
            default: active_code_o = 8'h00;
        endcase
    end

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && left_q > 1) |=> (left_q == $past(left_q) - 1'b1));
    assert_len_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (left_q <= LEFT_W'(MAX_BITS + 8)));
endmodule

// File: rtl/snc_capture.sv
// Capture side: shifts sampled input bits into the capture window in generic
// frames and into the status byte in status-read frames.
// Assumes mode_i reads M_IDLE whenever no frame is running.
module snc_capture
    import snc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode_i,
    input  logic             sdi_i,
    output logic [CAP_W-1:0] cap_o,
    output logic [7:0]       status_o
);
    logic [CAP_W-1:0] chain_q;
    logic [7:0]       stat_q;
    logic             gen_shift;

    assign gen_shift = (mode_i == M_GEN);

    // Sample one input bit per clock into the structure the mode selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            stat_q  <= '0;
        end else begin
            if (gen_shift)           chain_q <= {chain_q[CAP_W-2:0], sdi_i};
            if (mode_i == M_RDST)    stat_q  <= {stat_q[6:0], sdi_i};
        end
    end

    assign cap_o    = chain_q;
    assign status_o = stat_q;

    assert_cap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_shift |=> $stable(chain_q));
endmodule

// File: rtl/ser_cmd_shifter.sv
// Top: programmable serial command shifter. Wires the register file, the
// frame engine and the capture chain together. Assumes spi_sdi is already
// synchronous to clk.
module ser_cmd_shifter
    import snc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        spi_cs_n,
    output logic        spi_sdo,
    input  logic        spi_sdi
);
    logic             busy, start;
    logic [7:0]       code, count, active_code, status;
    logic [PRG_W-1:0] prg;
    logic [CAP_W-1:0] cap;
    mode_e            mode;

    snc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .busy_i(busy), .active_code_i(active_code),
        .status_i(status), .cap_i(cap), .count_o(count), .prg_o(prg),
        .start_o(start), .code_o(code), .rdata_o(reg_rdata)
    );

    snc_engine u_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code),
        .count_i(count), .prg_i(prg), .busy_o(busy), .sdo_o(spi_sdo),
        .mode_o(mode), .active_code_o(active_code)
    );

    snc_capture u_capture (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .sdi_i(spi_sdi),
        .cap_o(cap), .status_o(status)
    );

    assign spi_cs_n = !busy;

    assert_busy_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> (active_code == CODE_GEN || active_code == CODE_RDST ||
                       active_code == CODE_WRST));
endmodule

// File: tb/ser_cmd_shifter_tb_top.sv
module ser_cmd_shifter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_cs_n, spi_sdo;
    logic       spi_sdi = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Behavioural reference model
    bit         exp_q[$];
    logic [7:0] m_prg[6];
    logic [7:0] m_count = 0;
    logic [7:0] m_status = 0;
    logic [79:0] m_chain = '0;
    logic [7:0] m_code = 0;
    bit         m_live = 0;

    ser_cmd_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sdo(spi_sdo), .spi_sdi(spi_sdi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void push_byte(input logic [7:0] b, inout int n);
        for (int i = 7; i >= 0; i--) if (n > 0) begin exp_q.push_back(b[i]); n--; end
    endfunction

    // Model: consume a bit per busy clock, then accept writes when idle.
    always @(posedge clk) begin
        bit busy_now;
        busy_now = (exp_q.size() != 0);
        if (!rst_n) begin
            exp_q.delete();
            foreach (m_prg[i]) m_prg[i] = 0;
            m_count = 0; m_status = 0; m_chain = '0; m_code = 0; m_live = 1;
        end else begin
            if (busy_now) begin
                if (m_code == 8'h04) m_chain = {m_chain[78:0], spi_sdi};
                if (m_code == 8'h02) m_status = {m_status[6:0], spi_sdi};
                void'(exp_q.pop_front());
            end
            if (reg_we && !busy_now) begin
                if (reg_addr == 1) m_count = reg_wdata;
                if (reg_addr >= 3 && reg_addr <= 8) m_prg[reg_addr-3] = reg_wdata;
                if (reg_addr == 0) begin
                    int n;
                    n = (m_count > 56) ? 56 : int'(m_count);
                    m_code = reg_wdata;
                    case (reg_wdata)
                        8'h04: begin
                            for (int b = 5; b >= 0; b--) push_byte(m_prg[b], n);
                            while (n > 0) begin exp_q.push_back(1'b0); n--; end
                        end
                        8'h02: begin
                            int k; k = 16;
                            push_byte(8'h05, k); push_byte(8'h00, k);
                        end
                        8'h20: begin
                            int k; k = 8;
                            push_byte(8'h01, k);
                            for (int b = 5; b >= 0; b--) push_byte(m_prg[b], n);
                            while (n > 0) begin exp_q.push_back(1'b0); n--; end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Compare pins to the model every clock, then drive the next input bit.
    always @(negedge clk) begin
        if (rst_n && m_live) begin
            bit e_cs, e_sdo;
            e_cs  = (exp_q.size() == 0);
            e_sdo = e_cs ? 1'b0 : exp_q[0];
            check(spi_cs_n == e_cs, "R3 cs_n", spi_cs_n, e_cs);
            check(spi_sdo == e_sdo, "R4/R7/R8 sdo", spi_sdo, e_sdo);
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        spi_sdi = lfsr[0];
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int e, input string req);
        reg_addr = 5'(a);
        #1;
        check(reg_rdata == 8'(e), req, reg_rdata, e);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_caps(input string req);
        for (int k = 0; k < 10; k++) rd_chk(9 + k, m_chain[8*k +: 8], req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        rd_chk(0, 0, "R1 cmd"); rd_chk(1, 0, "R1 count");
        rd_chk(2, 0, "R1 status"); rd_chk(8, 0, "R1 prg5"); rd_chk(9, 0, "R1 cap0");
        check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);

        // R2: idle writes stored
        wr(1, 32); wr(8, 8'h9F);
        for (int i = 0; i < 5; i++) wr(3 + i, 0);
        rd_chk(1, 32, "R2 count"); rd_chk(8, 8'h9F, "R2 prg5");

        // R3 R5 R6: 4-byte generic frame, 3-byte response
        wr(0, 8'h04);
        rd_chk(0, 8'h04, "R6 busy code");
        wait_idle();
        rd_chk(0, 0, "R6 done code");
        chk_caps("R5 capture");

        // R4: opcode plus four transmit bytes; R2/R9: writes while busy refused
        wr(1, 40); wr(8, 8'h02); wr(7, 8'h12); wr(6, 8'h34); wr(5, 8'h56); wr(4, 8'hAB);
        wr(0, 8'h04);
        wr(8, 8'hEE); wr(0, 8'h20); wr(1, 8'h07);
        wait_idle();
        rd_chk(8, 8'h02, "R2 prg5 held while busy");
        rd_chk(1, 40, "R2 count held while busy");
        rd_chk(0, 0, "R9 no second frame");
        chk_caps("R5 capture after second frame");

        // R7: status read
        wr(0, 8'h02);
        rd_chk(0, 8'h02, "R6 status-read code");
        wait_idle();
        rd_chk(2, m_status, "R7 status");
        chk_caps("R7 capture unchanged");

        // R8: status write
        wr(1, 8); wr(8, 8'hA5);
        wr(0, 8'h20);
        wait_idle();
        chk_caps("R8 capture unchanged");
        rd_chk(2, m_status, "R8 status unchanged");

        // R10: oversize count
        wr(1, 8'h50);
        for (int i = 0; i < 6; i++) wr(3 + i, 8'h3C + 8'(i * 17));
        wr(0, 8'h04);
        wait_idle();
        rd_chk(1, 8'h50, "R10 count readback");
        chk_caps("R10 capture 56 bits");

        // R9: unknown code
        wr(0, 8'h08);
        check(spi_cs_n == 1'b1, "R9 unknown code cs_n", spi_cs_n, 1);
        rd_chk(0, 0, "R9 unknown code cmd");

        // R3: zero count starts nothing
        wr(1, 0); wr(0, 8'h04);
        check(spi_cs_n == 1'b1, "R3 zero count cs_n", spi_cs_n, 1);
        rd_chk(0, 0, "R3 zero count cmd");
        chk_caps("R3 zero count capture");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule